// File: doc/BRIEF.md
# Slot Interrupt Combiner

This block merges the interrupt requests of four plug-in module slots into a single host interrupt line. Every slot presents two active-low request pins. Each pin can be enabled or ignored on its own, and each can be treated as level or edge sensitive. Enabled requests are recorded in a shared 16-bit status word. That word also holds a sticky timeout flag per slot and an error flag per slot that follows its input.

Software reaches the block through a small 16-bit register window. Four byte offsets hold the slot control bytes, one holds the status word, and two are read-as-zero placeholders. A status bit is cleared in one of two ways. Software can write a one to the status bit, which also sends a one-cycle clear pulse back toward the module. Alternatively, software can read the module's interrupt-acknowledge location, which clears the request only when it is level sensitive.

Level-sensitive status bits drive the host line for as long as they are set. A newly recorded edge-sensitive request inverts the line for exactly one cycle.

Top module: `slot_irq_combiner`

## Requirements
- R1: During and right after reset, `host_irq` is low, `slot_clr` is zero, every control byte reads 0 and the status word reads 0.
- R2: A request whose enable bit (control bit 6+n of its slot) is clear never changes its status bit, whether the pin changes, a one is written to that bit, or an acknowledge read targets it.
- R3: When the pin of an enabled request s/n goes low, status bit s*2+n is set on the third rising clock edge after the change (two synchroniser flops, then edge detection). When the pin returns high, the bit is cleared after the same delay.
- R4: `host_irq` is high while any status interrupt bit is set whose edge-select bit (control bit 4+n of its slot) is clear. Bits with edge select set never hold the line.
- R5: When an enabled, edge-selected request whose status bit was clear goes active, `host_irq` takes the inverse of its level-driven value for exactly one cycle, in the cycle its status bit becomes visible, and then returns to the level-driven value.
- R6: A high `tmo_in[s]` on a clock edge sets status bit 12+s. The bit stays set until a one is written to that position of the status word. It drives `host_irq` only while control bit 2 of slot s is set.
- R7: Status bit 8+s equals `err_in[s]` from the previous clock edge. Writes to bits 8..11 have no effect. The bit drives `host_irq` only while control bit 3 of slot s is set.
- R8: A write to the status offset (0x0C) with bit s*2+n set drives `slot_clr[s*2+n]` high for the single cycle after the write edge. In that same edge it clears status bit s*2+n, provided the request is enabled.
- R9: An acknowledge read (`ack_rd`) to slot `ack_slot` at `ack_offs` 0 or 2 selects input 0 or 1. It clears that status bit and pulses the matching `slot_clr` bit only if the bit is set and edge select is clear. Any other offset, or an edge-selected bit, is left unchanged.
- R10: Register window, byte offsets: 0x02, 0x04, 0x06 and 0x08 are the control bytes of slots 0 to 3 (slot = offset/2-1), held in data bits 7:0 with bits 15:8 reading 0. 0x0C is the status word. 0x00 and 0x0A, and every other offset, read 0 and ignore writes. Read data appears on `reg_rdata` one clock after `reg_rd`.
- R11: Control bits 0 and 1 are stored and read back but do not change interrupt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 8 | Active-low module requests, bit s*2+n = slot s input n (asynchronous) |
| tmo_in | input | 4 | Per-slot timeout event, synchronous |
| err_in | input | 4 | Per-slot error level, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after reg_rd |
| ack_rd | input | 1 | Read strobe into a module's interrupt-acknowledge space |
| ack_slot | input | 2 | Slot targeted by the acknowledge read |
| ack_offs | input | 6 | Offset within the acknowledge space |
| slot_clr | output | 8 | One-cycle clear pulse toward each module request |
| host_irq | output | 1 | Combined host interrupt line, active high |

## Verification
The bench first targets the interaction between edge and level requests. It raises an edge-selected request while a level request already holds the line, and expects the line to drop for exactly one cycle. A design that OR-ed the pulse into the line would show no change there. A design that failed to mask edge-selected bits would leave the line stuck high. The bench then checks that disabled requests leave no trace in the status word, and that control bytes with only the unused low bits set behave like plain enables. It checks that an acknowledge read on an edge-selected request, or at a wrong offset, changes nothing. It also checks that writing ones to the error field does not disturb bits that mirror the error inputs. A design that mishandled any of these would either drop a pending interrupt or clear one it should keep.

// File: rtl/slot_irq_pkg.sv
// Package: shared constants for the slot interrupt combiner.
// Assumes an 8-bit control byte per slot and two request inputs per slot.
package slot_irq_pkg;
    localparam int CTRL_W        = 8;
    localparam int REQS_PER_SLOT = 2;
    // control byte bit positions
    localparam int CB_CLK_RATE   = 0;
    localparam int CB_RECOVER    = 1;
    localparam int CB_TMO_IE     = 2;
    localparam int CB_ERR_IE     = 3;
    localparam int CB_EDGE_LO    = 4;
    localparam int CB_EN_LO      = 6;

    typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/slot_irq_sync.sv
// Module: slot_irq_sync
// Brings the active-low module requests into the clock domain through two
// flops and compares the synchronised level with a registered copy, which
// yields one-cycle rise and fall strobes (rise = request became active).
// Assumes each pin stays stable for at least two clock periods.
module slot_irq_sync #(
    parameter int NREQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_n_i,
    output logic [NREQ-1:0] rise_o,
    output logic [NREQ-1:0] fall_o
);
    logic [NREQ-1:0] meta_q;
    logic [NREQ-1:0] sync_q;
    logic [NREQ-1:0] prev_q;

    for (genvar i = 0; i < NREQ; i++) begin : g_bit
        // Purpose: two-stage synchroniser plus history flop for one request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= ~req_n_i[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end

        assign rise_o[i] = sync_q[i] & ~prev_q[i];
        assign fall_o[i] = ~sync_q[i] & prev_q[i];
    end
endmodule

// File: rtl/slot_irq_regs.sv
// Module: slot_irq_regs
// Register window: per-slot control bytes, status read-back and decode of
// status writes into write-one-to-clear masks. Read data is registered.
// Assumes STAT_W <= DATA_W and that the status offset fits in ADDR_W bits.
module slot_irq_regs
    import slot_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    localparam int NREQ     = NUM_SLOTS * REQS_PER_SLOT,
    localparam int STAT_W   = NREQ + 2 * NUM_SLOTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [STAT_W-1:0]    status_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [NREQ-1:0]      en_o,
    output logic [NREQ-1:0]      edge_o,
    output logic [NUM_SLOTS-1:0] tmo_ie_o,
    output logic [NUM_SLOTS-1:0] err_ie_o,
    output logic [NREQ-1:0]      w1c_int_o,
    output logic [NUM_SLOTS-1:0] w1c_tmo_o
);
    localparam int TMO_LO = NREQ + NUM_SLOTS;
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(2 * (NUM_SLOTS + 2));
    // interrupt and timeout fields are clearable, error field is not
    localparam logic [DATA_W-1:0] W1C_MASK =
        DATA_W'({{NUM_SLOTS{1'b1}}, {NUM_SLOTS{1'b0}}, {NREQ{1'b1}}});

    ctrl_t              ctrl_q [NUM_SLOTS];
    logic [DATA_W-1:0]  rd_val;
    logic [DATA_W-1:0]  w1c_bits;
    logic               stat_hit;

    // Purpose: load a control byte when its offset is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) ctrl_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_i && addr_i == ADDR_W'(2 * (s + 1)))
                    ctrl_q[s] <= wdata_i[CTRL_W-1:0];
            end
        end
    end

    // Purpose: select the value a read at addr_i returns.
    always_comb begin
        rd_val = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (addr_i == ADDR_W'(2 * (s + 1)))
                rd_val = DATA_W'(ctrl_q[s]);
        end
        if (addr_i == STAT_OFF)
            rd_val = DATA_W'(status_i);
    end

    // Purpose: register read data so the output has a full cycle of timing.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_val;
    end

    assign stat_hit  = wr_i && (addr_i == STAT_OFF);
    assign w1c_bits  = stat_hit ? (wdata_i & W1C_MASK) : '0;
    assign w1c_int_o = w1c_bits[NREQ-1:0];
    assign w1c_tmo_o = w1c_bits[TMO_LO +: NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar n = 0; n < REQS_PER_SLOT; n++) begin : g_in
            assign en_o[s*REQS_PER_SLOT+n]   = ctrl_q[s][CB_EN_LO+n];
            assign edge_o[s*REQS_PER_SLOT+n] = ctrl_q[s][CB_EDGE_LO+n];
        end
        assign tmo_ie_o[s] = ctrl_q[s][CB_TMO_IE];
        assign err_ie_o[s] = ctrl_q[s][CB_ERR_IE];
    end
endmodule

// File: rtl/slot_irq_status.sv
// Module: slot_irq_status
// Holds the status word: per-request interrupt bits, error mirror bits and
// sticky timeout bits. Generates module clear pulses and the one-cycle
// edge-event strobe. Assumes rise/fall strobes are single-cycle.
module slot_irq_status
    import slot_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int NREQ     = NUM_SLOTS * REQS_PER_SLOT,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int OFFS_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      en_i,
    input  logic [NREQ-1:0]      edge_i,
    input  logic [NREQ-1:0]      rise_i,
    input  logic [NREQ-1:0]      fall_i,
    input  logic [NUM_SLOTS-1:0] tmo_i,
    input  logic [NUM_SLOTS-1:0] err_i,
    input  logic [NREQ-1:0]      w1c_int_i,
    input  logic [NUM_SLOTS-1:0] w1c_tmo_i,
    input  logic                 ack_rd_i,
    input  logic [SLOT_W-1:0]    ack_slot_i,
    input  logic [OFFS_W-1:0]    ack_offs_i,
    output logic [NREQ-1:0]      stat_int_o,
    output logic [NUM_SLOTS-1:0] stat_err_o,
    output logic [NUM_SLOTS-1:0] stat_tmo_o,
    output logic [NREQ-1:0]      clr_o,
    output logic                 fire_o
);
    logic [NREQ-1:0] int_d;
    logic [NREQ-1:0] clr_d;
    logic [NREQ-1:0] fire_vec;
    logic [NREQ-1:0] ack_hit;

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        localparam int S = i / REQS_PER_SLOT;
        localparam int N = i % REQS_PER_SLOT;

        // acknowledge only clears a pending level-sensitive request
        assign ack_hit[i] = ack_rd_i
                          && (ack_slot_i == SLOT_W'(S))
                          && (ack_offs_i == OFFS_W'(2 * N))
                          && stat_int_o[i] && !edge_i[i];

        assign clr_d[i] = w1c_int_i[i] | ack_hit[i];

        // a fresh edge-sensitive event toggles the host line for a cycle
        assign fire_vec[i] = en_i[i] & edge_i[i] & rise_i[i] & ~stat_int_o[i];

        // Purpose: next value of one interrupt status bit.
        always_comb begin
            int_d[i] = stat_int_o[i];
            if (en_i[i]) begin
                if (rise_i[i])
                    int_d[i] = 1'b1;
                else if (fall_i[i] || clr_d[i])
                    int_d[i] = 1'b0;
            end
        end
    end

    // Purpose: update status word, clear pulses and edge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_int_o <= '0;
            stat_err_o <= '0;
            stat_tmo_o <= '0;
            clr_o      <= '0;
            fire_o     <= 1'b0;
        end else begin
            stat_int_o <= int_d;
            stat_err_o <= err_i;
            stat_tmo_o <= (stat_tmo_o & ~w1c_tmo_i) | tmo_i;
            clr_o      <= clr_d;
            fire_o     <= |fire_vec;
        end
    end
endmodule

// File: rtl/slot_irq_host.sv
// Module: slot_irq_host
// Forms the host line: level-driven sources with edge-selected bits masked
// out, timeout and error flags gated by their enables, and the edge strobe
// inverting the result for one cycle. Purely combinational from registers.
module slot_irq_host #(
    parameter int NUM_SLOTS = 4,
    localparam int NREQ     = NUM_SLOTS * 2
) (
    input  logic [NREQ-1:0]      stat_int_i,
    input  logic [NREQ-1:0]      edge_i,
    input  logic [NUM_SLOTS-1:0] stat_tmo_i,
    input  logic [NUM_SLOTS-1:0] tmo_ie_i,
    input  logic [NUM_SLOTS-1:0] stat_err_i,
    input  logic [NUM_SLOTS-1:0] err_ie_i,
    input  logic                 fire_i,
    output logic                 host_irq_o
);
    logic level_any;

    // Purpose: collapse all level-driven sources into one bit.
    always_comb begin
        level_any = |(stat_int_i & ~edge_i)
                  | |(stat_tmo_i & tmo_ie_i)
                  | |(stat_err_i & err_ie_i);
    end

    assign host_irq_o = level_any ^ fire_i;
endmodule

// File: rtl/slot_irq_combiner.sv
// Module: slot_irq_combiner (top)
// Combines two active-low requests from each module slot into one host
// interrupt with per-request enable and edge/level selection, a register
// window and an acknowledge path. Assumes a single clock, synchronous reset.
module slot_irq_combiner
    import slot_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    localparam int NREQ     = NUM_SLOTS * REQS_PER_SLOT,
    localparam int STAT_W   = NREQ + 2 * NUM_SLOTS,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_n,
    input  logic [NUM_SLOTS-1:0] tmo_in,
    input  logic [NUM_SLOTS-1:0] err_in,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 ack_rd,
    input  logic [SLOT_W-1:0]    ack_slot,
    input  logic [5:0]           ack_offs,
    output logic [NREQ-1:0]      slot_clr,
    output logic                 host_irq
);
    logic [NREQ-1:0]      rise;
    logic [NREQ-1:0]      fall;
    logic [NREQ-1:0]      req_en;
    logic [NREQ-1:0]      req_edge;
    logic [NUM_SLOTS-1:0] tmo_ie;
    logic [NUM_SLOTS-1:0] err_ie;
    logic [NREQ-1:0]      w1c_int;
    logic [NUM_SLOTS-1:0] w1c_tmo;
    logic [NREQ-1:0]      stat_int;
    logic [NUM_SLOTS-1:0] stat_err;
    logic [NUM_SLOTS-1:0] stat_tmo;
    logic [STAT_W-1:0]    stat_q;
    logic                 edge_fire;

    assign stat_q = {stat_tmo, stat_err, stat_int};

    slot_irq_sync #(.NREQ(NREQ)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (req_n),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    slot_irq_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .rd_i      (reg_rd),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .status_i  (stat_q),
        .rdata_o   (reg_rdata),
        .en_o      (req_en),
        .edge_o    (req_edge),
        .tmo_ie_o  (tmo_ie),
        .err_ie_o  (err_ie),
        .w1c_int_o (w1c_int),
        .w1c_tmo_o (w1c_tmo)
    );

    slot_irq_status #(.NUM_SLOTS(NUM_SLOTS)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (req_en),
        .edge_i     (req_edge),
        .rise_i     (rise),
        .fall_i     (fall),
        .tmo_i      (tmo_in),
        .err_i      (err_in),
        .w1c_int_i  (w1c_int),
        .w1c_tmo_i  (w1c_tmo),
        .ack_rd_i   (ack_rd),
        .ack_slot_i (ack_slot),
        .ack_offs_i (ack_offs),
        .stat_int_o (stat_int),
        .stat_err_o (stat_err),
        .stat_tmo_o (stat_tmo),
        .clr_o      (slot_clr),
        .fire_o     (edge_fire)
    );

    slot_irq_host #(.NUM_SLOTS(NUM_SLOTS)) u_host (
        .stat_int_i (stat_int),
        .edge_i     (req_edge),
        .stat_tmo_i (stat_tmo),
        .tmo_ie_i   (tmo_ie),
        .stat_err_i (stat_err),
        .err_ie_i   (err_ie),
        .fire_i     (edge_fire),
        .host_irq_o (host_irq)
    );
endmodule

// File: rtl/slot_irq_combiner_chk.sv
// Module: slot_irq_combiner_chk
// Temporal checks on the combiner, bound into every instance of the top.
module slot_irq_combiner_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    localparam int NREQ     = NUM_SLOTS * 2,
    localparam int STAT_W   = NREQ + 2 * NUM_SLOTS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_irq,
    input logic [NREQ-1:0]      slot_clr,
    input logic [NUM_SLOTS-1:0] err_in,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 ack_rd,
    input logic [NREQ-1:0]      req_en,
    input logic [STAT_W-1:0]    stat_q
);
    localparam int ERR_LO = NREQ;
    localparam int TMO_LO = NREQ + NUM_SLOTS;
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(2 * (NUM_SLOTS + 2));

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!host_irq && slot_clr == '0 && stat_q == '0)); // R1

    AST_ERR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_q[ERR_LO +: NUM_SLOTS] == $past(err_in))); // R7

    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_clr != '0) |-> ($past(reg_wr && reg_addr == STAT_OFF) || $past(ack_rd))); // R8

    AST_REV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_rd && reg_addr == '0)) |-> (reg_rdata == '0)); // R10

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(req_en[i]) |-> (stat_q[i] == $past(stat_q[i]))); // R2
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_tmo
        AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(stat_q[TMO_LO+s]) && !$past(reg_wr && reg_addr == STAT_OFF))
            |-> stat_q[TMO_LO+s]); // R6
    end
endmodule

bind slot_irq_combiner slot_irq_combiner_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_irq  (host_irq),
    .slot_clr  (slot_clr),
    .err_in    (err_in),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ack_rd    (ack_rd),
    .req_en    (req_en),
    .stat_q    (stat_q)
);

// File: tb/tb_slot_irq_combiner.sv
`timescale 1ns/1ps
module tb_slot_irq_combiner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_n = 8'hFF;
    logic [3:0]  tmo_in = '0;
    logic [3:0]  err_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ack_rd = 1'b0;
    logic [1:0]  ack_slot = '0;
    logic [5:0]  ack_offs = '0;
    logic [7:0]  slot_clr;
    logic        host_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] rd;

    localparam logic [3:0] STAT = 4'hC;

    // {slot[1:0], input, control byte, expected status, expected host level}
    localparam logic [27:0] VEC [0:7] = '{
        {2'd0, 1'b0, 8'h40, 16'h0001, 1'b1},  // R3 level, enabled
        {2'd1, 1'b1, 8'h80, 16'h0008, 1'b1},  // R3 input 1
        {2'd2, 1'b0, 8'h00, 16'h0000, 1'b0},  // R2 disabled
        {2'd3, 1'b1, 8'h40, 16'h0000, 1'b0},  // R2 other input enabled only
        {2'd3, 1'b0, 8'h50, 16'h0040, 1'b0},  // R4 edge bit masked
        {2'd1, 1'b0, 8'h43, 16'h0004, 1'b1},  // R11 low bits inert
        {2'd2, 1'b1, 8'hA0, 16'h0020, 1'b0},  // R4 edge on input 1
        {2'd0, 1'b1, 8'hC0, 16'h0002, 1'b1}   // R3 both enabled
    };

    slot_irq_combiner dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .tmo_in(tmo_in), .err_in(err_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_rd(ack_rd), .ack_slot(ack_slot), .ack_offs(ack_offs),
        .slot_clr(slot_clr), .host_irq(host_irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_n = 8'hFF; tmo_in = '0; err_in = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic ack(input logic [1:0] s, input logic [5:0] o);
        ack_rd = 1'b1; ack_slot = s; ack_offs = o;
        @(posedge clk);
        @(negedge clk);
        ack_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check({15'd0, host_irq}, 16'd0, "R1 host after reset");
        check({8'd0, slot_clr}, 16'd0, "R1 slot_clr after reset");
        reg_read(STAT, rd); check(rd, 16'h0000, "R1 status after reset");
        reg_read(4'h2, rd); check(rd, 16'h0000, "R1 ctrl A after reset");
        reg_read(4'h8, rd); check(rd, 16'h0000, "R1 ctrl D after reset");

        // table walk: R2 R3 R4 R11
        for (int k = 0; k < 8; k++) begin
            logic [27:0] v;
            int idx;
            v = VEC[k];
            idx = int'(v[27:26]) * 2 + int'(v[25]);
            do_reset();
            reg_write(4'(2 * (int'(v[27:26]) + 1)), {8'h00, v[24:17]});
            req_n[idx] = 1'b0;
            settle();
            reg_read(STAT, rd);
            check(rd, v[16:1], $sformatf("R3 vec %0d status on assert", k));
            check({15'd0, host_irq}, {15'd0, v[0]}, $sformatf("R4 vec %0d host level", k));
            req_n[idx] = 1'b1;
            settle();
            reg_read(STAT, rd);
            check(rd, 16'h0000, $sformatf("R3 vec %0d status on release", k));
            check({15'd0, host_irq}, 16'd0, $sformatf("R4 vec %0d host after release", k));
        end

        // R5 edge pulse with no level source: one high cycle
        do_reset();
        reg_write(4'h4, 16'h0050);
        req_n[2] = 1'b0;
        settle();
        check({15'd0, host_irq}, 16'd1, "R5 pulse high");
        @(negedge clk);
        check({15'd0, host_irq}, 16'd0, "R5 pulse ends");

        // R5 edge pulse while a level source holds the line: one low cycle
        do_reset();
        reg_write(4'h2, 16'h0040);
        reg_write(4'h4, 16'h0050);
        req_n[0] = 1'b0;
        settle();
        check({15'd0, host_irq}, 16'd1, "R4 level holds line");
        req_n[2] = 1'b0;
        settle();
        check({15'd0, host_irq}, 16'd0, "R5 inverted pulse");
        @(negedge clk);
        check({15'd0, host_irq}, 16'd1, "R5 returns to level");

        // R6 timeout flags
        do_reset();
        tmo_in[2] = 1'b1;
        @(negedge clk);
        tmo_in[2] = 1'b0;
        reg_read(STAT, rd); check(rd, 16'h4000, "R6 timeout sticky");
        check({15'd0, host_irq}, 16'd0, "R6 timeout gated off");
        reg_write(4'h6, 16'h0004);
        check({15'd0, host_irq}, 16'd1, "R6 timeout enabled");
        reg_write(STAT, 16'h4000);
        reg_read(STAT, rd); check(rd, 16'h0000, "R6 timeout cleared");
        check({15'd0, host_irq}, 16'd0, "R6 host after clear");

        // R7 error mirror, writes ignored
        do_reset();
        err_in[1] = 1'b1;
        @(negedge clk);
        reg_read(STAT, rd); check(rd, 16'h0200, "R7 error mirrors input");
        check({15'd0, host_irq}, 16'd0, "R7 error gated off");
        reg_write(4'h4, 16'h0008);
        check({15'd0, host_irq}, 16'd1, "R7 error enabled");
        reg_write(STAT, 16'h0F00);
        reg_read(STAT, rd); check(rd, 16'h0200, "R7 write to error field ignored");
        err_in[1] = 1'b0;
        @(negedge clk);
        reg_read(STAT, rd); check(rd, 16'h0000, "R7 error follows input low");

        // R8 status write clear
        do_reset();
        reg_write(4'h2, 16'h0040);
        req_n[0] = 1'b0;
        settle();
        check({15'd0, host_irq}, 16'd1, "R8 line before clear");
        reg_write(STAT, 16'h0001);
        check({8'd0, slot_clr}, 16'h0001, "R8 clear pulse");
        check({15'd0, host_irq}, 16'd0, "R8 line after clear");
        @(negedge clk);
        check({8'd0, slot_clr}, 16'h0000, "R8 clear pulse one cycle");
        reg_read(STAT, rd); check(rd, 16'h0000, "R8 status cleared");
        req_n[0] = 1'b1;

        // R2 write-one to a disabled request's bit leaves status alone
        do_reset();
        reg_write(4'h2, 16'h0040);
        req_n[0] = 1'b0;
        settle();
        reg_write(4'h2, 16'h0000);
        reg_write(STAT, 16'h0001);
        reg_read(STAT, rd); check(rd, 16'h0001, "R2 disabled bit not cleared");
        req_n[0] = 1'b1;

        // R9 acknowledge reads
        do_reset();
        reg_write(4'h2, 16'h0040);
        reg_write(4'h4, 16'h00A0);
        req_n[0] = 1'b0;
        req_n[3] = 1'b0;
        settle();
        reg_read(STAT, rd); check(rd, 16'h0009, "R9 both pending");
        ack(2'd1, 6'd2);
        check({8'd0, slot_clr}, 16'h0000, "R9 edge ack no pulse");
        reg_read(STAT, rd); check(rd, 16'h0009, "R9 edge ack keeps bit");
        ack(2'd0, 6'd4);
        check({8'd0, slot_clr}, 16'h0000, "R9 wrong offset no pulse");
        ack(2'd0, 6'd0);
        check({8'd0, slot_clr}, 16'h0001, "R9 level ack pulse");
        reg_read(STAT, rd); check(rd, 16'h0008, "R9 level ack clears");
        check({15'd0, host_irq}, 16'd0, "R9 line low after ack");

        // R10 register map
        do_reset();
        reg_write(4'h2, 16'hAB11);
        reg_write(4'h4, 16'h0022);
        reg_write(4'h6, 16'h0033);
        reg_write(4'h8, 16'h0004);
        reg_write(4'h0, 16'hFFFF);
        reg_write(4'hA, 16'hFFFF);
        reg_read(4'h0, rd); check(rd, 16'h0000, "R10 revision reads zero");
        reg_read(4'h2, rd); check(rd, 16'h0011, "R10 ctrl A low byte only");
        reg_read(4'h4, rd); check(rd, 16'h0022, "R10 ctrl B");
        reg_read(4'h6, rd); check(rd, 16'h0033, "R10 ctrl C");
        reg_read(4'h8, rd); check(rd, 16'h0004, "R10 ctrl D");
        reg_read(4'hA, rd); check(rd, 16'h0000, "R10 reset offset reads zero");
        reg_read(4'hE, rd); check(rd, 16'h0000, "R10 unmapped reads zero");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule